// File: doc/BRIEF.md
# Serial-Programmed Output Enable Controller

This block is the configuration logic of a two-bank clock fan-out device with five outputs per bank. A mode input selects between two behaviours. With the mode input low, every output is on and each bank repeats its own clock input. With the mode input high, an 11-bit configuration word is shifted in one bit per rising edge of the configuration clock. One further edge commits the word to a control register. That register then holds one enable per output plus a bank-source select, and it stays fixed until the next reset.

A reset happens on any configuration-clock edge taken with the mode input low. An asynchronous active-low reset input also exists; it is asserted at once and released in step with the configuration clock. An enabled output drives its bank's true and complement clock. A disabled output is parked with its true line low and its complement line high.

Top module: `outen_ser_ctrl`

## Requirements
- R1: While the mode input is high and the block is shifting, each rising edge of `cfg_clk` moves every stage of the 11-bit shift register one place along, and the first stage takes `ser_din`.
- R2: The shift register is not copied to the control register after fewer than eleven shifts. On the edge after the eleventh shift (the twelfth edge), it is copied, and the outputs follow the new word from then on.
- R3: Once the control register is committed, further edges with the mode input high change neither it nor the outputs, whatever `ser_din` carries.
- R4: A `cfg_clk` edge with the mode input low clears the shift counter, the shift register and the control register. The next high-mode sequence then loads a fresh word.
- R5: While the mode input is low, all ten outputs are enabled and each bank takes its own clock input, whatever the register contents.
- R6: Serial order: the first bit enables bank-B lane 4, then lanes 3, 2, 1 and 0 of bank B, then lanes 4 to 0 of bank A. The eleventh bit is the source select.
- R7: An enable bit of 1 turns its output on and 0 turns it off. An output that is off drives true = 0 and complement = 1.
- R8: An enabled output copies its source: true output = source true input, complement output = source complement input.
- R9: A select bit of 1 drives bank B from the bank-A inputs. A select bit of 0 leaves bank B on the bank-B inputs. Bank A always uses the bank-A inputs.
- R10: With the mode input high, all outputs are off from a reset until the commit edge, including while shifting and while waiting for the commit.
- R11: Driving `rst_n` low clears all state at once. With the mode input high, all outputs are then off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_prog | input | 1 | 1 = programmed mode, 0 = standard mode and sequencer reset |
| ser_din | input | 1 | Serial configuration data |
| clk_a_p | input | 1 | Bank-A clock, true |
| clk_a_n | input | 1 | Bank-A clock, complement |
| clk_b_p | input | 1 | Bank-B clock, true |
| clk_b_n | input | 1 | Bank-B clock, complement |
| qa_p | output | 5 | Bank-A outputs, true, index = lane |
| qa_n | output | 5 | Bank-A outputs, complement |
| qb_p | output | 5 | Bank-B outputs, true |
| qb_n | output | 5 | Bank-B outputs, complement |

## Verification
The shift register cannot be seen from the ports. Its contents show up only after a full twelve-edge sequence has locked them in. The bench therefore checks ordering by loading a single set bit at each of the ten enable positions in turn, with a sequencer reset between loads, and reading back which single lane turns on. Lock-out is reached by committing a word and then clocking a run of opposite data. The outputs must not move during that run.

// File: rtl/oecfg_pkg.sv
package oecfg_pkg;
  typedef enum logic [1:0] {
    PH_SHIFT = 2'd0,
    PH_WAIT  = 2'd1,
    PH_LOCK  = 2'd2
  } phase_e;
endpackage

// File: rtl/oecfg_rst_sync.sv
module oecfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/oecfg_seq.sv
module oecfg_seq #(
  parameter int unsigned WORD_W = 11,
  parameter int unsigned CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  output logic                clr,
  output logic                shift_en,
  output logic                commit_en,
  output oecfg_pkg::phase_e   phase,
  output logic [CNT_W-1:0]    cnt
);
  import oecfg_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    shift_en  = 1'b0;
    commit_en = 1'b0;
    clr       = 1'b0;
    if (!mode) begin
      clr     = 1'b1;
      phase_d = PH_SHIFT;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_SHIFT: begin
          shift_en = 1'b1;
          cnt_d    = cnt_q + 1'b1;
          if (cnt_q == LAST) phase_d = PH_WAIT;
        end
        PH_WAIT: begin
          commit_en = 1'b1;
          phase_d   = PH_LOCK;
        end
        PH_LOCK: phase_d = PH_LOCK;
        default: phase_d = PH_SHIFT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SHIFT;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/oecfg_regs.sv
module oecfg_regs #(
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              commit_en,
  input  logic              din,
  output logic [WORD_W-1:0] shreg,
  output logic [WORD_W-1:0] ctrl
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] ctl_q, ctl_d;

  always_comb begin
    sh_d  = sh_q;
    ctl_d = ctl_q;
    if (clr) begin
      sh_d  = '0;
      ctl_d = '0;
    end else begin
      if (shift_en)  sh_d  = {sh_q[WORD_W-2:0], din};
      if (commit_en) ctl_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      ctl_q <= '0;
    end else begin
      sh_q  <= sh_d;
      ctl_q <= ctl_d;
    end
  end

  assign shreg = sh_q;
  assign ctrl  = ctl_q;
endmodule

// File: rtl/oecfg_bank.sv
module oecfg_bank #(
  parameter int unsigned LANES = 5
) (
  input  logic [LANES-1:0] en,
  input  logic             src_p,
  input  logic             src_n,
  output logic [LANES-1:0] q_p,
  output logic [LANES-1:0] q_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign q_p[i] = en[i] & src_p;
    assign q_n[i] = ~en[i] | src_n;
  end
endmodule

// File: rtl/outen_ser_ctrl.sv
module outen_ser_ctrl #(
  parameter int unsigned LANES = 5
) (
  input  logic             cfg_clk,
  input  logic             rst_n,
  input  logic             mode_prog,
  input  logic             ser_din,
  input  logic             clk_a_p,
  input  logic             clk_a_n,
  input  logic             clk_b_p,
  input  logic             clk_b_n,
  output logic [LANES-1:0] qa_p,
  output logic [LANES-1:0] qa_n,
  output logic [LANES-1:0] qb_p,
  output logic [LANES-1:0] qb_n
);
  localparam int unsigned WORD_W = 2 * LANES + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
  localparam int unsigned A_LO   = 1;
  localparam int unsigned B_LO   = LANES + 1;

  logic              rst_s_n;
  logic              clr, shift_en, commit_en;
  oecfg_pkg::phase_e phase;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg, ctrl;
  logic [LANES-1:0]  en_a, en_b;
  logic              sel_a;
  logic              src_b_p, src_b_n;

  oecfg_rst_sync u_rst (
    .clk     (cfg_clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  oecfg_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk       (cfg_clk),
    .rst_n     (rst_s_n),
    .mode      (mode_prog),
    .clr       (clr),
    .shift_en  (shift_en),
    .commit_en (commit_en),
    .phase     (phase),
    .cnt       (cnt)
  );

  oecfg_regs #(.WORD_W(WORD_W)) u_regs (
    .clk       (cfg_clk),
    .rst_n     (rst_s_n),
    .clr       (clr),
    .shift_en  (shift_en),
    .commit_en (commit_en),
    .din       (ser_din),
    .shreg     (shreg),
    .ctrl      (ctrl)
  );

  assign en_a    = {LANES{~mode_prog}} | ctrl[A_LO +: LANES];
  assign en_b    = {LANES{~mode_prog}} | ctrl[B_LO +: LANES];
  assign sel_a   = mode_prog & ctrl[0];
  assign src_b_p = sel_a ? clk_a_p : clk_b_p;
  assign src_b_n = sel_a ? clk_a_n : clk_b_n;

  oecfg_bank #(.LANES(LANES)) u_bank_a (
    .en    (en_a),
    .src_p (clk_a_p),
    .src_n (clk_a_n),
    .q_p   (qa_p),
    .q_n   (qa_n)
  );

  oecfg_bank #(.LANES(LANES)) u_bank_b (
    .en    (en_b),
    .src_p (src_b_p),
    .src_n (src_b_n),
    .q_p   (qb_p),
    .q_n   (qb_n)
  );
endmodule

// File: rtl/outen_ser_ctrl_chk.sv
module outen_ser_ctrl_chk #(
  parameter int unsigned LANES  = 5,
  parameter int unsigned WORD_W = 11,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              mode,
  input logic              din,
  input oecfg_pkg::phase_e phase,
  input logic [CNT_W-1:0]  cnt,
  input logic [WORD_W-1:0] shreg,
  input logic [WORD_W-1:0] ctrl,
  input logic              clk_a_p,
  input logic              clk_a_n,
  input logic              clk_b_p,
  input logic              clk_b_n,
  input logic [LANES-1:0]  qa_p,
  input logic [LANES-1:0]  qa_n,
  input logic [LANES-1:0]  qb_p,
  input logic [LANES-1:0]  qb_n
);
  import oecfg_pkg::*;

  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode && phase == PH_SHIFT) |=> shreg == {$past(shreg[WORD_W-2:0]), $past(din)});

  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode && phase == PH_SHIFT && cnt == CNT_W'(WORD_W - 1)) |=> phase == PH_WAIT);

  assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode && phase == PH_WAIT) |=> (ctrl == $past(shreg) && phase == PH_LOCK));

  assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode && phase == PH_LOCK) |=> ($stable(ctrl) && phase == PH_LOCK));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mode |=> (ctrl == '0 && shreg == '0 && cnt == '0 && phase == PH_SHIFT));

  assert_std_on_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mode |-> (qa_p == {LANES{clk_a_p}} && qa_n == {LANES{clk_a_n}} &&
               qb_p == {LANES{clk_b_p}} && qb_n == {LANES{clk_b_n}}));

  assert_off_before_load_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode && phase != PH_LOCK) |-> (qa_p == '0 && qa_n == '1 && qb_p == '0 && qb_n == '1));

  assert_sel_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode && phase == PH_LOCK && ctrl[0] && ctrl[WORD_W-1]) |->
      (qb_p[LANES-1] == clk_a_p && qb_n[LANES-1] == clk_a_n));
endmodule

bind outen_ser_ctrl outen_ser_ctrl_chk #(
  .LANES(LANES), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (
  .clk     (cfg_clk),
  .rst_s_n (rst_s_n),
  .mode    (mode_prog),
  .din     (ser_din),
  .phase   (phase),
  .cnt     (cnt),
  .shreg   (shreg),
  .ctrl    (ctrl),
  .clk_a_p (clk_a_p),
  .clk_a_n (clk_a_n),
  .clk_b_p (clk_b_p),
  .clk_b_n (clk_b_n),
  .qa_p    (qa_p),
  .qa_n    (qa_n),
  .qb_p    (qb_p),
  .qb_n    (qb_n)
);

// File: tb/outen_ser_ctrl_tb.sv
`timescale 1ns/1ps
module outen_ser_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n, mode, din;
  logic       ap, an, bp, bn;
  logic [4:0] qa_p, qa_n, qb_p, qb_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  outen_ser_ctrl u_dut (
    .cfg_clk(clk), .rst_n(rst_n), .mode_prog(mode), .ser_din(din),
    .clk_a_p(ap), .clk_a_n(an), .clk_b_p(bp), .clk_b_n(bn),
    .qa_p(qa_p), .qa_n(qa_n), .qb_p(qb_p), .qb_n(qb_n)
  );

  // Compare all 20 output lines for both input polarities
  task automatic check_out(input logic [4:0] ea, input logic [4:0] eb,
                           input logic sel, input string req);
    for (int pol = 0; pol < 2; pol++) begin
      logic [19:0] exp_v, act_v;
      logic sbp, sbn;
      ap = pol[0]; an = ~pol[0]; bp = ~pol[0]; bn = pol[0];
      #1;
      sbp = sel ? ap : bp;
      sbn = sel ? an : bn;
      exp_v = {ea & {5{ap}}, ~ea | {5{an}}, eb & {5{sbp}}, ~eb | {5{sbn}}};
      act_v = {qa_p, qa_n, qb_p, qb_n};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s: outputs act=%b exp=%b", req, act_v, exp_v);
      end
    end
  endtask

  task automatic seq_reset();
    mode = 1'b0; din = 1'b0;
    @(negedge clk);
  endtask

  // w[10] is sent first; 11 edges shift, no commit
  task automatic shift_word(input logic [10:0] w, input bit mid_check);
    for (int i = 10; i >= 0; i--) begin
      mode = 1'b1; din = w[i];
      @(negedge clk);
      if (mid_check && i == 5) check_out(5'b0, 5'b0, 1'b0, "R10 mid-shift");
    end
  endtask

  task automatic load_word(input logic [10:0] w);
    seq_reset();
    shift_word(w, 1'b0);
    din = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; mode = 1'b1; din = 1'b0;
    #2;
    check_out(5'b0, 5'b0, 1'b0, "R11 async reset, all off");
    mode = 1'b0;
    check_out(5'b11111, 5'b11111, 1'b0, "R5 standard mode in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_standard();
    seq_reset();
    check_out(5'b11111, 5'b11111, 1'b0, "R5 R8 standard mode");
  endtask

  task automatic t_load_basic();
    logic [10:0] w = 11'b10110_01101_0;
    seq_reset();
    shift_word(w, 1'b1);
    check_out(5'b0, 5'b0, 1'b0, "R2 R10 after 11 shifts, before commit");
    din = 1'b1;
    @(negedge clk);
    check_out(w[5:1], w[10:6], 1'b0, "R1 R2 R7 R8 committed word");
  endtask

  task automatic t_locked();
    logic [10:0] w = 11'b01001_11010_0;
    load_word(w);
    for (int i = 0; i < 15; i++) begin
      din = i[0]; @(negedge clk);
    end
    check_out(w[5:1], w[10:6], 1'b0, "R3 locked after toggling data");
    shift_word(~w, 1'b0);
    @(negedge clk);
    check_out(w[5:1], w[10:6], 1'b0, "R3 locked after second full word");
  endtask

  task automatic t_reload_sel();
    logic [10:0] w = 11'b11111_00000_1;
    load_word(w);
    check_out(5'b00000, 5'b11111, 1'b1, "R4 R9 reload with select=1");
    load_word(11'b10001_10001_0);
    check_out(5'b10001, 5'b10001, 1'b0, "R4 R9 reload with select=0");
  endtask

  task automatic t_walk();
    for (int k = 1; k <= 10; k++) begin
      logic [10:0] w = 11'(1) << k;
      load_word(w);
      check_out(w[5:1], w[10:6], 1'b0, "R6 single-bit position");
    end
  endtask

  task automatic t_mode_drop();
    load_word(11'b00100_01000_0);
    mode = 1'b0;
    check_out(5'b11111, 5'b11111, 1'b0, "R5 mode low forces on at once");
    @(negedge clk);
    mode = 1'b1;
    check_out(5'b0, 5'b0, 1'b0, "R4 R10 cleared after mode-low edge");
  endtask

  task automatic t_async_mid();
    load_word(11'b11111_11111_0);
    #1 rst_n = 1'b0;
    #1 check_out(5'b0, 5'b0, 1'b0, "R11 async reset while locked");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    load_word(11'b00011_11000_0);
    check_out(5'b11000, 5'b00011, 1'b0, "R11 load after async reset");
  endtask

  initial begin
    ap = 0; an = 1; bp = 1; bn = 0;
    t_reset_state();
    t_standard();
    t_load_basic();
    t_locked();
    t_reload_sel();
    t_walk();
    t_mode_drop();
    t_async_mid();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule